// File: doc/BRIEF.md
# Outbound Address Translation Window Unit

This unit turns CPU-side addresses into bus-side addresses using a small bank of outbound regions. Each region holds a 64-bit base, a 32-bit limit, a 64-bit target, a transaction kind and two control flags: enable and configuration shift. Software never addresses a region directly. It first writes a viewport register that selects a direction and a region number. It then reaches that region's fields through one shared set of register offsets. The same offsets are used to read the fields back.

On the request side, each valid address is compared against all regions in parallel. If any enabled region matches, the lowest-numbered one is chosen. The output is that region's target plus the offset of the address into the region, together with the region's kind and number. Configuration regions with shift mode enabled form the output differently: the bus/device/function field in address bits 27:12 is placed at output bits 31:16, the register offset in bits 11:0 is kept, and the target is added to the result. An address that matches no region is passed through unchanged and flagged as a miss. All results are registered and appear one clock after the request.

Top module: `ob_xlate_win`

## Requirements
- R1: After reset every region field is zero and every region is disabled. Any register read returns 0, and every request misses.
- R2: The viewport register is at offset 0x900. Bit 31 selects the direction (1 = inbound, 0 = outbound) and bits 2:0 select the region. Reading it returns {bit31, 28 zeros, index}.
- R3: With outbound selected, the selected region's fields are read and written at these offsets: 0x904 kind (bits 4:0), 0x908 control (bit 31 enable, bit 28 shift), 0x90C base low, 0x910 base high, 0x914 limit, 0x918 target low, 0x91C target high. Read data appears one clock after the address.
- R4: While inbound is selected, writes to region offsets have no effect and reads of them return 0. A write changes only the selected region; every other region keeps its values.
- R5: A region hits when it is enabled, the 64-bit address is at or above its base, and the address's low 32 bits are at or below its limit. Both range edges are inclusive.
- R6: On a hit without shift, out_addr = target + (address − base). out_kind is the region's kind, using these codes: memory 0x0, I/O 0x2, configuration type 0 0x4, configuration type 1 0x5. out_region is the hit region's number.
- R7: Shift mode applies when the control shift bit is set and the kind is 0x4 or 0x5. In that case out_addr = target + {32'b0, address[27:12], 4'b0, address[11:0]}. A shift bit set on any other kind has no effect.
- R8: When several enabled regions hit, the one with the lowest number wins.
- R9: On a miss, out_miss = 1, out_addr equals the request address, out_kind = 0 and out_region = 0.
- R10: out_valid is req_valid delayed by one clock. When out_valid is low, out_miss is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 12 | Register offset for reads and writes |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Registered read data for the previous cycle's cfg_addr |
| req_valid | input | 1 | Translation request valid |
| req_addr | input | 64 | Untranslated CPU-side address |
| out_valid | output | 1 | Registered result valid |
| out_addr | output | 64 | Translated address, or the request address on a miss |
| out_kind | output | 5 | Transaction kind of the hit region |
| out_region | output | 3 | Number of the hit region |
| out_miss | output | 1 | No enabled region matched |

## Verification
The unit holds a lot of state that is easy to get wrong. If the viewport index or direction is corrupted, a write lands in the wrong region. That shows up at the next read of the region it should have changed, and at the first request that falls into either window. If a base, limit or enable is wrong, the unit produces a false hit or a false miss. A wrong target or kind, or a wrong shift decision, gives a wrong out_addr or out_kind. All of these are visible on the very next result, one clock after the request. So the bench probes both window edges, overlapping windows and shift-mode addresses directly after each change to the programming.

// File: rtl/obx_pkg.sv
package obx_pkg;
  localparam int CFG_AW = 12;
  localparam int KIND_W = 5;

  localparam logic [CFG_AW-1:0] OFF_VIEW = 12'h900;
  localparam logic [CFG_AW-1:0] OFF_KIND = 12'h904;
  localparam logic [CFG_AW-1:0] OFF_CTRL = 12'h908;
  localparam logic [CFG_AW-1:0] OFF_BLO  = 12'h90C;
  localparam logic [CFG_AW-1:0] OFF_BHI  = 12'h910;
  localparam logic [CFG_AW-1:0] OFF_LIM  = 12'h914;
  localparam logic [CFG_AW-1:0] OFF_TLO  = 12'h918;
  localparam logic [CFG_AW-1:0] OFF_THI  = 12'h91C;

  localparam logic [KIND_W-1:0] KIND_MEM  = 5'h0;
  localparam logic [KIND_W-1:0] KIND_IO   = 5'h2;
  localparam logic [KIND_W-1:0] KIND_CFG0 = 5'h4;
  localparam logic [KIND_W-1:0] KIND_CFG1 = 5'h5;

  typedef struct packed {
    logic              en;
    logic              shift;
    logic [KIND_W-1:0] kind;
    logic [63:0]       base;
    logic [31:0]       limit;
    logic [63:0]       target;
  } region_t;
endpackage

// File: rtl/obx_regs.sv
module obx_regs
  import obx_pkg::*;
#(
  parameter int NUM_REGIONS = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           we,
  input  logic [CFG_AW-1:0]              addr,
  input  logic [31:0]                    wdata,
  output logic [31:0]                    rdata,
  output region_t [NUM_REGIONS-1:0]      regions
);
  logic        vp_in;
  logic [2:0]  vp_idx;
  logic [31:0] rd_next;

  always_comb begin
    rd_next = '0;
    if (addr == OFF_VIEW) rd_next = {vp_in, 28'h0, vp_idx};
    for (int i = 0; i < NUM_REGIONS; i++) begin
      if (!vp_in && 32'(vp_idx) == i) begin
        case (addr)
          OFF_KIND: rd_next = {27'h0, regions[i].kind};
          OFF_CTRL: rd_next = {regions[i].en, 2'b00, regions[i].shift, 28'h0};
          OFF_BLO:  rd_next = regions[i].base[31:0];
          OFF_BHI:  rd_next = regions[i].base[63:32];
          OFF_LIM:  rd_next = regions[i].limit;
          OFF_TLO:  rd_next = regions[i].target[31:0];
          OFF_THI:  rd_next = regions[i].target[63:32];
          default:  ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vp_in   <= 1'b0;
      vp_idx  <= '0;
      regions <= '0;
      rdata   <= '0;
    end else begin
      rdata <= rd_next;
      if (we && addr == OFF_VIEW) begin
        vp_in  <= wdata[31];
        vp_idx <= wdata[2:0];
      end
      for (int i = 0; i < NUM_REGIONS; i++) begin
        if (we && !vp_in && 32'(vp_idx) == i) begin
          case (addr)
            OFF_KIND: regions[i].kind <= wdata[KIND_W-1:0];
            OFF_CTRL: begin
              regions[i].en    <= wdata[31];
              regions[i].shift <= wdata[28];
            end
            OFF_BLO:  regions[i].base[31:0]    <= wdata;
            OFF_BHI:  regions[i].base[63:32]   <= wdata;
            OFF_LIM:  regions[i].limit         <= wdata;
            OFF_TLO:  regions[i].target[31:0]  <= wdata;
            OFF_THI:  regions[i].target[63:32] <= wdata;
            default:  ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/obx_cmp.sv
module obx_cmp
  import obx_pkg::*;
#(
  parameter int NUM_REGIONS = 8
) (
  input  logic [63:0]                     addr,
  input  region_t [NUM_REGIONS-1:0]       regions,
  output logic [NUM_REGIONS-1:0]          hit,
  output logic [NUM_REGIONS-1:0][63:0]    xaddr
);
  logic [63:0] bdf_form;
  assign bdf_form = {32'h0, addr[27:12], 4'h0, addr[11:0]};

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_win
    logic is_cfg;
    logic use_shift;
    assign is_cfg    = (regions[g].kind == KIND_CFG0) || (regions[g].kind == KIND_CFG1);
    assign use_shift = regions[g].shift && is_cfg;
    assign hit[g]    = regions[g].en && (addr >= regions[g].base) &&
                       (addr[31:0] <= regions[g].limit);
    assign xaddr[g]  = use_shift ? (regions[g].target + bdf_form)
                                 : (regions[g].target + (addr - regions[g].base));
  end
endmodule

// File: rtl/obx_pick.sv
module obx_pick
  import obx_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  parameter int IDX_W       = 3
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            req_valid,
  input  logic [63:0]                     req_addr,
  input  logic [NUM_REGIONS-1:0]          hit,
  input  logic [NUM_REGIONS-1:0][63:0]    xaddr,
  input  region_t [NUM_REGIONS-1:0]       regions,
  output logic                            out_valid,
  output logic [63:0]                     out_addr,
  output logic [KIND_W-1:0]               out_kind,
  output logic [IDX_W-1:0]                out_region,
  output logic                            out_miss
);
  logic             any_hit;
  logic [IDX_W-1:0] sel;

  always_comb begin
    any_hit = 1'b0;
    sel     = '0;
    for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
      if (hit[i]) begin
        any_hit = 1'b1;
        sel     = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_addr   <= '0;
      out_kind   <= '0;
      out_region <= '0;
      out_miss   <= 1'b0;
    end else begin
      out_valid <= req_valid;
      if (req_valid) begin
        if (any_hit) begin
          out_addr   <= xaddr[sel];
          out_kind   <= regions[sel].kind;
          out_region <= sel;
          out_miss   <= 1'b0;
        end else begin
          out_addr   <= req_addr;
          out_kind   <= KIND_MEM;
          out_region <= '0;
          out_miss   <= 1'b1;
        end
      end else begin
        out_miss <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ob_xlate_win.sv
module ob_xlate_win
  import obx_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  localparam int IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [11:0]       cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              req_valid,
  input  logic [63:0]       req_addr,
  output logic              out_valid,
  output logic [63:0]       out_addr,
  output logic [4:0]        out_kind,
  output logic [IDX_W-1:0]  out_region,
  output logic              out_miss
);
  region_t [NUM_REGIONS-1:0]       regions;
  logic [NUM_REGIONS-1:0]          hit;
  logic [NUM_REGIONS-1:0][63:0]    xaddr;

  obx_regs #(.NUM_REGIONS(NUM_REGIONS)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .regions(regions)
  );

  obx_cmp #(.NUM_REGIONS(NUM_REGIONS)) u_cmp (
    .addr(req_addr), .regions(regions), .hit(hit), .xaddr(xaddr)
  );

  obx_pick #(.NUM_REGIONS(NUM_REGIONS), .IDX_W(IDX_W)) u_pick (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .hit(hit), .xaddr(xaddr), .regions(regions),
    .out_valid(out_valid), .out_addr(out_addr), .out_kind(out_kind),
    .out_region(out_region), .out_miss(out_miss)
  );
endmodule

// File: rtl/obx_chk.sv
module obx_chk #(
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic [63:0]      req_addr,
  input logic             out_valid,
  input logic [63:0]      out_addr,
  input logic [4:0]       out_kind,
  input logic [IDX_W-1:0] out_region,
  input logic             out_miss
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> out_valid); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!out_valid && !out_miss)); // R10
  AST_MISS_PASSTHRU: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (!out_miss || out_addr == $past(req_addr))); // R9
  AST_MISS_FIELDS: assert property (@(posedge clk) disable iff (rst)
    out_miss |-> (out_kind == 5'h0 && out_region == '0)); // R9
endmodule

bind ob_xlate_win obx_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
  .out_valid(out_valid), .out_addr(out_addr), .out_kind(out_kind),
  .out_region(out_region), .out_miss(out_miss)
);

// File: tb/tb_ob_xlate_win.sv
module tb_ob_xlate_win;
  localparam int NR = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [11:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic [63:0] req_addr = '0;
  logic        out_valid;
  logic [63:0] out_addr;
  logic [4:0]  out_kind;
  logic [2:0]  out_region;
  logic        out_miss;

  always #10 clk = ~clk;

  ob_xlate_win #(.NUM_REGIONS(NR)) dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
    .req_addr(req_addr), .out_valid(out_valid), .out_addr(out_addr),
    .out_kind(out_kind), .out_region(out_region), .out_miss(out_miss)
  );

  int checks = 0;
  int errors = 0;

  // bench model of programmed state
  logic [63:0] m_base [NR];
  logic [63:0] m_tgt  [NR];
  logic [31:0] m_lim  [NR];
  logic [4:0]  m_kind [NR];
  bit          m_en   [NR];
  bit          m_sh   [NR];
  bit          m_in;
  logic [2:0]  m_idx;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NR; i++) begin
      m_base[i] = '0; m_tgt[i] = '0; m_lim[i] = '0;
      m_kind[i] = '0; m_en[i] = 0; m_sh[i] = 0;
    end
    m_in = 0; m_idx = '0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (a == 12'h900) begin
      m_in = d[31]; m_idx = d[2:0];
    end else if (!m_in) begin
      case (a)
        12'h904: m_kind[m_idx] = d[4:0];
        12'h908: begin m_en[m_idx] = d[31]; m_sh[m_idx] = d[28]; end
        12'h90C: m_base[m_idx][31:0]  = d;
        12'h910: m_base[m_idx][63:32] = d;
        12'h914: m_lim[m_idx]         = d;
        12'h918: m_tgt[m_idx][31:0]   = d;
        12'h91C: m_tgt[m_idx][63:32]  = d;
        default: ;
      endcase
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [11:0] a);
    if (a == 12'h900) return {m_in, 28'h0, m_idx};
    if (m_in) return '0;
    case (a)
      12'h904: return {27'h0, m_kind[m_idx]};
      12'h908: return {m_en[m_idx], 2'b00, m_sh[m_idx], 28'h0};
      12'h90C: return m_base[m_idx][31:0];
      12'h910: return m_base[m_idx][63:32];
      12'h914: return m_lim[m_idx];
      12'h918: return m_tgt[m_idx][31:0];
      12'h91C: return m_tgt[m_idx][63:32];
      default: return '0;
    endcase
  endfunction

  task automatic rd_chk(input string tag, input logic [11:0] a);
    @(negedge clk);
    cfg_addr = a;
    @(negedge clk);
    chk(tag, {32'h0, cfg_rdata}, {32'h0, exp_rd(a)});
  endtask

  task automatic prog(input int i, input logic [63:0] base, input logic [31:0] size,
                      input logic [63:0] tgt, input logic [4:0] kind, input bit en, input bit sh);
    wr(12'h900, 32'(i));
    wr(12'h90C, base[31:0]);
    wr(12'h910, base[63:32]);
    wr(12'h914, base[31:0] + size - 32'd1);
    wr(12'h918, tgt[31:0]);
    wr(12'h91C, tgt[63:32]);
    wr(12'h904, {27'h0, kind});
    wr(12'h908, {en, 2'b00, sh, 28'h0});
  endtask

  task automatic expect_of(input logic [63:0] a, output bit miss, output logic [63:0] oa,
                           output logic [4:0] k, output logic [2:0] ri);
    miss = 1; oa = a; k = '0; ri = '0;
    for (int i = 0; i < NR; i++) begin
      if (miss && m_en[i] && a >= m_base[i] && a[31:0] <= m_lim[i]) begin
        miss = 0; k = m_kind[i]; ri = 3'(i);
        if (m_sh[i] && (m_kind[i] == 5'h4 || m_kind[i] == 5'h5))
          oa = m_tgt[i] + {32'h0, a[27:12], 4'h0, a[11:0]};
        else
          oa = m_tgt[i] + (a - m_base[i]);
      end
    end
  endtask

  task automatic do_req(input string tag, input logic [63:0] a);
    bit e_miss; logic [63:0] e_addr; logic [4:0] e_kind; logic [2:0] e_reg;
    expect_of(a, e_miss, e_addr, e_kind, e_reg);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " R10 valid"}, {63'h0, out_valid}, 64'h1);
    chk({tag, " miss"}, {63'h0, out_miss}, {63'h0, e_miss});
    chk({tag, " addr"}, out_addr, e_addr);
    chk({tag, " kind"}, {59'h0, out_kind}, {59'h0, e_kind});
    chk({tag, " region"}, {61'h0, out_region}, {61'h0, e_reg});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0A17));
    model_reset();
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd_chk("R1 ctrl region0", 12'h908);
    rd_chk("R1 base low region0", 12'h90C);
    rd_chk("R1 viewport", 12'h900);
    do_req("R1 reset miss", 64'h0000_0000_0000_1234);
    do_req("R1 reset miss zero", 64'h0);

    // R2 viewport fields
    wr(12'h900, 32'h0000_0005);
    rd_chk("R2 viewport outbound idx5", 12'h900);
    wr(12'h900, 32'h8000_0003);
    rd_chk("R2 viewport inbound idx3", 12'h900);

    // R3 register readback
    prog(2, 64'h0000_0001_2000_0000, 32'h0010_0000, 64'h0000_0040_0000_0000, 5'h0, 1, 0);
    for (int o = 0; o < 8; o++) rd_chk("R3 readback", 12'h900 + 12'(4 * o));

    // R4 ignored writes
    wr(12'h900, 32'h8000_0002);
    wr(12'h90C, 32'hDEAD_0000);
    rd_chk("R4 inbound read zero", 12'h90C);
    wr(12'h900, 32'h0000_0002);
    rd_chk("R4 inbound write ignored", 12'h90C);
    wr(12'h900, 32'h0000_0003);
    wr(12'h90C, 32'h7777_0000);
    wr(12'h900, 32'h0000_0002);
    rd_chk("R4 other region unchanged", 12'h90C);
    do_req("R4 window intact", 64'h0000_0001_2000_0010);

    // R5 edges and R6 translation
    do_req("R5 below base", 64'h0000_0001_1FFF_FFFF);
    do_req("R5 at base R6", 64'h0000_0001_2000_0000);
    do_req("R5 at limit R6", 64'h0000_0001_200F_FFFF);
    do_req("R5 above limit", 64'h0000_0001_2010_0000);

    // R6 kinds
    prog(4, 64'h0000_0000_5000_0000, 32'h0001_0000, 64'h0000_0000_0000_0000, 5'h2, 1, 0);
    do_req("R6 io kind", 64'h0000_0000_5000_0abc);
    prog(5, 64'h0000_0000_6000_0000, 32'h0000_1000, 64'h0000_0000_0010_0000, 5'h5, 1, 0);
    do_req("R6 cfg1 kind", 64'h0000_0000_6000_0ff8);

    // R7 shift mode
    prog(1, 64'h0000_0000_E000_0000, 32'h0100_0000, 64'h0, 5'h4, 1, 1);
    do_req("R7 shift cfg0", 64'h0000_0000_E021_9040);
    prog(6, 64'h0000_0000_7000_0000, 32'h0100_0000, 64'h0000_0000_0800_0000, 5'h0, 1, 1);
    do_req("R7 shift on mem ignored", 64'h0000_0000_7012_3456);

    // R8 priority
    prog(0, 64'h0000_0000_7000_0000, 32'h0010_0000, 64'h0000_0000_9000_0000, 5'h0, 1, 0);
    do_req("R8 lowest wins", 64'h0000_0000_7000_1000);
    wr(12'h900, 32'h0);
    wr(12'h908, 32'h0);
    do_req("R8 next after disable", 64'h0000_0000_7000_1000);

    // R10 idle
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk("R10 idle valid", {63'h0, out_valid}, 64'h0);
    chk("R10 idle miss", {63'h0, out_miss}, 64'h0);

    // constrained random
    for (int it = 0; it < 600; it++) begin
      if ($urandom_range(0, 9) == 0) begin
        logic [4:0] kinds [4];
        kinds[0] = 5'h0; kinds[1] = 5'h2; kinds[2] = 5'h4; kinds[3] = 5'h5;
        prog($urandom_range(0, NR - 1),
             {32'($urandom_range(0, 3)), 20'($urandom_range(0, 32'h000E_FFFF)), 12'h0},
             32'($urandom_range(1, 256)) << 12,
             {32'($urandom_range(0, 15)), $urandom},
             kinds[$urandom_range(0, 3)], bit'($urandom_range(0, 3) != 0),
             bit'($urandom_range(0, 1)));
      end else begin
        int j;
        logic [31:0] sz;
        logic [63:0] a;
        j  = $urandom_range(0, NR - 1);
        sz = m_lim[j] - m_base[j][31:0] + 32'd1;
        case ($urandom_range(0, 3))
          0: a = m_base[j] + 64'($urandom_range(0, sz - 1));
          1: a = m_base[j] - 64'd1;
          2: a = m_base[j] + 64'(sz);
          default: a = {$urandom, $urandom};
        endcase
        do_req("R5 R6 R7 R8 R9 random", a);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule